// File: doc/BRIEF.md
# Dual Output-Compare Timer

This block is a free-running up-counter with two compare channels, each of which owns one output pin. Software programs a control word and two compare values through a small synchronous write port and reads every register back through a combinational read port. When the counter equals a channel's compare value, a programmed level is placed on that channel's pin. Software can also force either pin to its programmed level directly, without waiting for a compare.

Two special modes reshape channel A's pin into a waveform. In repeating mode, compare B reloads the counter to its start value. In single-shot mode, compare B halts the counter instead. In both modes, compare A drives level A onto pin A and compare B drives level B onto pin A. The counter advances only on cycles where the external tick enable is high, which lets a prescaler elsewhere set the count rate.

Top module: `ocmp_timer`

## Requirements
- R1: After reset the counter holds 0xFFFC, both pins are 0, both compare registers are 0 and the control word reads 0.
- R2: The counter increases by one at each clock edge where the run bit (control bit 0) and `tick` are both 1. It holds its value otherwise, and it wraps from 0xFFFF to 0x0000.
- R3: Address 0 is the control word, address 1 is compare A, address 2 is compare B and address 3 is the counter. Writes to address 3 are ignored.
- R4: In normal mode (control bits 1 and 2 both clear), if compare-enable A (bit 3) is set and a counting cycle finds the counter equal to compare A, pin A takes level A (bit 5) at that edge. Pin A never takes level B in this mode.
- R5: In any mode, if compare-enable B (bit 4) is set and a counting cycle finds the counter equal to compare B, pin B takes level B (bit 6) at that edge. Without the enable, pin B is unchanged by compares.
- R6: A control write with force-A (bit 7) or force-B (bit 8) set copies that channel's level bit from the same write data onto its pin at that edge, taking precedence over a compare. A force bit written as 0 has no effect on the pin.
- R7: The control word reads back bits 6:0 as stored. Bits 15:7, including both force bits, always read 0.
- R8: In repeating mode (bit 1), pin A takes level A on a compare-A match and level B on a compare-B match, with B winning if both match and no compare enables needed. On the compare-B match the counter reloads to 0xFFFC instead of incrementing.
- R9: In single-shot mode (bit 2 set, bit 1 clear), the compares drive pin A as in R8. On the compare-B match the counter keeps its value and the run bit clears, unless a control write in that cycle sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| pin_a | output | 1 | Channel A output |
| pin_b | output | 1 | Channel B output |

## Verification
Every effect in this block appears exactly one clock edge after the cycle that causes it:
- a register write,
- a force strobe,
- a counter step,
- a compare match that moves a pin,
- the single-shot stop.

Read data is combinational from the address and the current registers. The bench drives inputs on the falling edge and holds a tick high for exactly N rising edges. It then samples the pins and read data at the next falling edge, with the address settled for a nanosecond. Each expected count is therefore the start value plus N, adjusted for the reloads and halts that the requirements state.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CMPA = 2'd1;
    localparam logic [1:0] ADDR_CMPB = 2'd2;
    localparam logic [1:0] ADDR_CNT  = 2'd3;

    localparam int CTRL_BITS = 7;
    localparam int F_FRC_A   = 7;
    localparam int F_FRC_B   = 8;

    // stored control bits, run is bit 0
    typedef struct packed {
        logic lvl_b;
        logic lvl_a;
        logic en_b;
        logic en_a;
        logic onep;
        logic pwm;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/ocmp_match.sv
module ocmp_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic         step,
    output logic         hit
);
    always_comb begin
        hit = step && (cnt == cmp);
    end
endmodule

// File: rtl/ocmp_pin_next.sv
module ocmp_pin_next (
    input  logic shaped,
    input  logic en_a,
    input  logic en_b,
    input  logic lvl_a,
    input  logic lvl_b,
    input  logic hit_a,
    input  logic hit_b,
    input  logic frc_a,
    input  logic frc_b,
    input  logic frc_lvl_a,
    input  logic frc_lvl_b,
    input  logic pin_a_q,
    input  logic pin_b_q,
    output logic pin_a_d,
    output logic pin_b_d
);
    always_comb begin
        pin_a_d = pin_a_q;
        if (shaped) begin
            if (hit_a) pin_a_d = lvl_a;
            if (hit_b) pin_a_d = lvl_b;
        end else if (hit_a && en_a) begin
            pin_a_d = lvl_a;
        end
        if (frc_a) pin_a_d = frc_lvl_a;

        pin_b_d = pin_b_q;
        if (hit_b && en_b) pin_b_d = lvl_b;
        if (frc_b) pin_b_d = frc_lvl_b;
    end
endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer #(
    parameter int         W      = 16,
    parameter logic [W-1:0] RELOAD = 16'hFFFC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         pin_a,
    output logic         pin_b
);
    import ocmp_pkg::*;

    localparam int NCH = 2;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cmp_a;
        logic [W-1:0] cmp_b;
        ctrl_t        ctrl;
        logic         pin_a;
        logic         pin_b;
    } state_t;

    localparam state_t RST_STATE = '{cnt: RELOAD, cmp_a: '0, cmp_b: '0,
                                     ctrl: '0, pin_a: 1'b0, pin_b: 1'b0};

    state_t s_q, s_d;

    logic                    step;
    logic [NCH-1:0]          hit;
    logic [NCH-1:0][W-1:0]   cmp_arr;
    logic                    wr_ctrl;
    logic                    pin_a_nx, pin_b_nx;

    // plain views for the bound checker
    logic [W-1:0] cnt_now, cmpb_now;
    logic         run_now, pwm_now, op_now;

    assign step       = s_q.ctrl.run && tick;
    assign cmp_arr[0] = s_q.cmp_a;
    assign cmp_arr[1] = s_q.cmp_b;
    assign wr_ctrl    = wr_en && (addr == ADDR_CTRL);

    assign cnt_now  = s_q.cnt;
    assign cmpb_now = s_q.cmp_b;
    assign run_now  = s_q.ctrl.run;
    assign pwm_now  = s_q.ctrl.pwm;
    assign op_now   = s_q.ctrl.onep;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
        ocmp_match #(.W(W)) u_match (
            .cnt  (s_q.cnt),
            .cmp  (cmp_arr[ch]),
            .step (step),
            .hit  (hit[ch])
        );
    end

    ocmp_pin_next u_pins (
        .shaped    (s_q.ctrl.pwm || s_q.ctrl.onep),
        .en_a      (s_q.ctrl.en_a),
        .en_b      (s_q.ctrl.en_b),
        .lvl_a     (s_q.ctrl.lvl_a),
        .lvl_b     (s_q.ctrl.lvl_b),
        .hit_a     (hit[0]),
        .hit_b     (hit[1]),
        .frc_a     (wr_ctrl && wdata[F_FRC_A]),
        .frc_b     (wr_ctrl && wdata[F_FRC_B]),
        .frc_lvl_a (wdata[5]),
        .frc_lvl_b (wdata[6]),
        .pin_a_q   (s_q.pin_a),
        .pin_b_q   (s_q.pin_b),
        .pin_a_d   (pin_a_nx),
        .pin_b_d   (pin_b_nx)
    );

    always_comb begin
        s_d = s_q;
        if (step) begin
            if (s_q.ctrl.pwm && hit[1]) begin
                s_d.cnt = RELOAD;
            end else if (s_q.ctrl.onep && hit[1]) begin
                s_d.ctrl.run = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + W'(1);
            end
        end
        if (wr_en) begin
            case (addr)
                ADDR_CTRL: s_d.ctrl  = ctrl_t'(wdata[CTRL_BITS-1:0]);
                ADDR_CMPA: s_d.cmp_a = wdata;
                ADDR_CMPB: s_d.cmp_b = wdata;
                default:   ;
            endcase
        end
        s_d.pin_a = pin_a_nx;
        s_d.pin_b = pin_b_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_STATE;
        else        s_q <= s_d;
    end

    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = W'(s_q.ctrl);
            ADDR_CMPA: rdata = s_q.cmp_a;
            ADDR_CMPB: rdata = s_q.cmp_b;
            default:   rdata = s_q.cnt;
        endcase
    end

    assign pin_a = s_q.pin_a;
    assign pin_b = s_q.pin_b;

endmodule

// File: rtl/ocmp_timer_chk.sv
module ocmp_timer_chk #(
    parameter int           W      = 16,
    parameter logic [W-1:0] RELOAD = 16'hFFFC
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         wr_ctrl,
    input logic         frc_b,
    input logic [W-8:0] ctrl_hi,
    input logic         rd_ctrl,
    input logic         pin_b,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp_b,
    input logic         run,
    input logic         pwm,
    input logic         onep
);
    // R2: no step, no movement
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && tick) |=> $stable(cnt));

    // R2: ordinary step adds one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !((pwm || onep) && cnt == cmp_b)) |=> cnt == $past(cnt) + W'(1));

    // R8: repeating mode reloads on compare B
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && pwm && cnt == cmp_b) |=> cnt == RELOAD);

    // R9: single-shot halts on compare B
    a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !pwm && onep && cnt == cmp_b && !wr_ctrl) |=> (!run && $stable(cnt)));

    // R7: upper control bits read as zero
    a_r7_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |-> ctrl_hi == '0);

    // R5: pin B moves only on a B match or a B force
    a_r5_pinb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_ctrl && frc_b) && !(run && tick && cnt == cmp_b)) |=> $stable(pin_b));
endmodule

bind ocmp_timer ocmp_timer_chk #(.W(W), .RELOAD(RELOAD)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_ctrl (wr_ctrl),
    .frc_b   (wdata[8]),
    .ctrl_hi (rdata[W-1:7]),
    .rd_ctrl (addr == 2'd0),
    .pin_b   (pin_b),
    .cnt     (cnt_now),
    .cmp_b   (cmpb_now),
    .run     (run_now),
    .pwm     (pwm_now),
    .onep    (op_now)
);

// File: tb/sim_ocmp_timer.sv
`timescale 1ns/1ps
module sim_ocmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        pin_a, pin_b;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ocmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_a(pin_a), .pin_b(pin_b)
    );

    task automatic expect_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 16'h0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        do_reset();
        rd(2'd3, v); expect_eq("R1 counter", v, 16'hFFFC);
        rd(2'd0, v); expect_eq("R1 control", v, 16'h0000);
        rd(2'd1, v); expect_eq("R1 compare A", v, 16'h0000);
        expect_eq("R1 pins", {14'h0, pin_a, pin_b}, 16'h0000);
    endtask

    task automatic t_count;
        logic [15:0] v;
        do_reset();
        wr(2'd0, 16'h0001);
        repeat (3) @(negedge clk);
        rd(2'd3, v); expect_eq("R2 hold without tick", v, 16'hFFFC);
        ticks(3);
        rd(2'd3, v); expect_eq("R2 three steps", v, 16'hFFFF);
        ticks(1);
        rd(2'd3, v); expect_eq("R2 wrap", v, 16'h0000);
        wr(2'd0, 16'h0000);
        ticks(2);
        rd(2'd3, v); expect_eq("R2 hold when stopped", v, 16'h0000);
    endtask

    task automatic t_map;
        logic [15:0] v;
        do_reset();
        wr(2'd1, 16'h1234);
        wr(2'd2, 16'hBEEF);
        rd(2'd1, v); expect_eq("R3 compare A readback", v, 16'h1234);
        rd(2'd2, v); expect_eq("R3 compare B readback", v, 16'hBEEF);
        wr(2'd3, 16'h5555);
        rd(2'd3, v); expect_eq("R3 counter write ignored", v, 16'hFFFC);
    endtask

    task automatic t_force;
        logic [15:0] v;
        do_reset();
        wr(2'd0, 16'h01E0);
        expect_eq("R6 force high", {14'h0, pin_a, pin_b}, 16'h0003);
        rd(2'd0, v); expect_eq("R7 force bits read 0", v, 16'h0060);
        wr(2'd0, 16'h0180);
        expect_eq("R6 force low", {14'h0, pin_a, pin_b}, 16'h0000);
        wr(2'd0, 16'h0060);
        expect_eq("R6 zero force no effect", {14'h0, pin_a, pin_b}, 16'h0000);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); expect_eq("R7 reserved read 0", v, 16'h007F);
        expect_eq("R6 all-ones force", {14'h0, pin_a, pin_b}, 16'h0003);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_cmp_a;
        logic [15:0] v;
        do_reset();
        wr(2'd1, 16'h0003);
        wr(2'd2, 16'h0003);
        wr(2'd0, 16'h0069);
        ticks(7);
        rd(2'd3, v); expect_eq("R4 at compare value", v, 16'h0003);
        expect_eq("R4 pin A before match edge", {15'h0, pin_a}, 16'h0000);
        ticks(1);
        expect_eq("R4 pin A after match", {15'h0, pin_a}, 16'h0001);
        expect_eq("R5 pin B disabled", {15'h0, pin_b}, 16'h0000);
    endtask

    task automatic t_cmp_b;
        logic [15:0] v;
        do_reset();
        wr(2'd2, 16'h0001);
        wr(2'd0, 16'h0051);
        ticks(5);
        rd(2'd3, v); expect_eq("R5 at compare value", v, 16'h0001);
        expect_eq("R5 pin B before match", {15'h0, pin_b}, 16'h0000);
        ticks(1);
        expect_eq("R5 pin B after match", {15'h0, pin_b}, 16'h0001);
        expect_eq("R4 normal mode keeps A", {15'h0, pin_a}, 16'h0000);
    endtask

    task automatic t_one_pulse;
        logic [15:0] v;
        do_reset();
        wr(2'd1, 16'h0001);
        wr(2'd2, 16'h0003);
        wr(2'd0, 16'h0025);
        ticks(5);
        expect_eq("R9 pin A idle", {15'h0, pin_a}, 16'h0000);
        ticks(1);
        expect_eq("R9 pin A rises on A", {15'h0, pin_a}, 16'h0001);
        ticks(2);
        expect_eq("R9 pin A falls on B", {15'h0, pin_a}, 16'h0000);
        rd(2'd3, v); expect_eq("R9 counter held", v, 16'h0003);
        rd(2'd0, v); expect_eq("R9 run cleared", v, 16'h0024);
        ticks(2);
        rd(2'd3, v); expect_eq("R9 stays stopped", v, 16'h0003);
    endtask

    task automatic t_pwm;
        logic [15:0] v;
        do_reset();
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0002);
        wr(2'd0, 16'h0023);
        ticks(5);
        expect_eq("R8 pin A set on A", {15'h0, pin_a}, 16'h0001);
        rd(2'd3, v); expect_eq("R8 counter after A", v, 16'h0001);
        ticks(2);
        expect_eq("R8 pin A cleared on B", {15'h0, pin_a}, 16'h0000);
        rd(2'd3, v); expect_eq("R8 reload", v, 16'hFFFC);
        ticks(5);
        expect_eq("R8 second period", {15'h0, pin_a}, 16'h0001);
        rd(2'd3, v); expect_eq("R8 second period count", v, 16'h0001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_count();
        t_map();
        t_force();
        t_cmp_a();
        t_cmp_b();
        t_one_pulse();
        t_pwm();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule